// File: doc/BRIEF.md
# Delayed Lockstep Output Comparator

This block sits between a main core and a redundant checker core that runs the same program two clock cycles later. Every input that the main core sees is passed through a two-stage register chain and handed to the checker core. The main core's output bundle goes through a matching two-stage chain so that, in each cycle, it lines up with the outputs the checker core produces from the delayed inputs. Both bundles are then compared bit for bit.

The comparison is split into independent channels. Each channel covers its own slice of the output bundle and drives its own sticky fault line toward the fault collection logic. A fault stays set until software pulses that channel's clear strobe. Alongside each fault the block passes out a 2-bit reaction code, captured from the configuration input when the fault is set. It also passes out the XOR of the two slices from the first failing cycle, which shows which bits diverged. A single enable turns lockstep checking on or off. After reset, and after each time checking is enabled, comparison waits until the delay chains hold data from enabled cycles.

Top module: `lockstep_cmp`

## Requirements
- R1: `chk_in_o` equals the value `main_in_i` held two clock edges earlier.
- R2: In a valid compare cycle, a difference in any bit between channel c's slice of `main_out_i` from two edges earlier and the same slice of `chk_out_i` sets `fault_o[c]` at the next clock edge.
- R3: `fault_o[c]` stays set until a cycle in which `clr_i[c]` is high. It is low from the edge that samples that clear, unless R4 applies.
- R4: When a mismatch and `clr_i[c]` occur in the same cycle, detection wins and `fault_o[c]` stays set.
- R5: While `en_i` is low no fault is set. Faults already set keep their value.
- R6: A cycle is a valid compare cycle only if `en_i` is high in that cycle and was also sampled high at the two preceding clock edges. Reset counts as not enabled.
- R7: On the edge that sets `fault_o[c]`, slice c of `first_diff_o` loads the bitwise XOR of the two compared slices. It holds that value through later mismatches and returns to zero on a clear that is not overridden by R4.
- R8: On the edge that sets `fault_o[c]`, slice c of `react_o` (2 bits) loads `react_cfg_i`. The codes are 0 none, 1 interrupt, 2 alarm, 3 reset. The slice is 0 whenever the fault is low.
- R9: Channels are independent. A mismatch or clear on one channel does not change another channel's fault, capture or reaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Lockstep checking enable |
| react_cfg_i | input | 2 | Reaction code to attach to a new fault |
| clr_i | input | NUM_CH | Per-channel fault clear strobe |
| main_in_i | input | IN_W | Main core input bundle |
| chk_in_o | output | IN_W | Input bundle delayed two cycles for the checker core |
| main_out_i | input | NUM_CH*OUT_W | Main core output bundle, channel c in bits [c*OUT_W +: OUT_W] |
| chk_out_i | input | NUM_CH*OUT_W | Checker core output bundle, same layout |
| fault_o | output | NUM_CH | Sticky out-of-sync fault per channel |
| react_o | output | NUM_CH*2 | Captured reaction code per channel |
| first_diff_o | output | NUM_CH*OUT_W | XOR of the first failing cycle per channel |

## Verification
The bench injects single-bit and multi-bit differences into the checker outputs and expects each fault on exactly the edge after the compare cycle. A design with the main outputs realigned by the wrong number of stages would fault on clean traffic or report on the wrong cycle. Injections in the first two enabled cycles after reset, and after re-enabling, must be ignored; a missing warm-up qualifier would raise faults from stale pipeline data. A clear that arrives together with a fresh mismatch must leave the fault set, and a capture that is overwritten by later mismatches or survives a clear would show the wrong XOR pattern. Mismatches while disabled, and traffic on one channel only, check that nothing leaks across the enable or between channels.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned LSC_DLY = 2;

  typedef enum logic [1:0] {
    RX_NONE  = 2'd0,
    RX_IRQ   = 2'd1,
    RX_ALARM = 2'd2,
    RX_RESET = 2'd3
  } react_e;
endpackage

// File: rtl/lsc_delay.sv
module lsc_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/lsc_warmup.sv
module lsc_warmup #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic vld_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  // compare only once both delay stages hold enabled-cycle data
  assign vld_o = en_i && (cnt_q == FULL);
endmodule

// File: rtl/lsc_channel.sv
module lsc_channel #(
  parameter int unsigned W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmp_vld_i,
  input  logic               clr_i,
  input  logic [W-1:0]       main_i,
  input  logic [W-1:0]       chk_i,
  input  lsc_pkg::react_e    react_cfg_i,
  output logic               fault_o,
  output lsc_pkg::react_e    react_o,
  output logic [W-1:0]       first_diff_o
);
  import lsc_pkg::*;

  logic [W-1:0] diff;
  logic         det;
  logic         fault_q;
  react_e       react_q;
  logic [W-1:0] cap_q;

  assign diff = main_i ^ chk_i;
  assign det  = cmp_vld_i && (|diff);

  // detection beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= det | (fault_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '0;
      react_q <= RX_NONE;
    end else if (det && !fault_q) begin
      cap_q   <= diff;
      react_q <= react_cfg_i;
    end else if (clr_i && !det) begin
      cap_q   <= '0;
      react_q <= RX_NONE;
    end
  end

  assign fault_o      = fault_q;
  assign react_o      = react_q;
  assign first_diff_o = cap_q;
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp #(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned OUT_W  = 8,
  parameter int unsigned NUM_CH = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [1:0]              react_cfg_i,
  input  logic [NUM_CH-1:0]       clr_i,
  input  logic [IN_W-1:0]         main_in_i,
  output logic [IN_W-1:0]         chk_in_o,
  input  logic [NUM_CH*OUT_W-1:0] main_out_i,
  input  logic [NUM_CH*OUT_W-1:0] chk_out_i,
  output logic [NUM_CH-1:0]       fault_o,
  output logic [NUM_CH*2-1:0]     react_o,
  output logic [NUM_CH*OUT_W-1:0] first_diff_o
);
  import lsc_pkg::*;

  localparam int unsigned BW = NUM_CH * OUT_W;

  logic [BW-1:0] main_dly;
  logic          cmp_vld;
  react_e        react_cfg;

  assign react_cfg = react_e'(react_cfg_i);

  lsc_delay #(.W(IN_W), .DEPTH(LSC_DLY)) u_in_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (main_in_i),
    .q_o   (chk_in_o)
  );

  lsc_delay #(.W(BW), .DEPTH(LSC_DLY)) u_out_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (main_out_i),
    .q_o   (main_dly)
  );

  lsc_warmup #(.DEPTH(LSC_DLY)) u_warm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .vld_o (cmp_vld)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    react_e ch_react;

    lsc_channel #(.W(OUT_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmp_vld_i   (cmp_vld),
      .clr_i       (clr_i[c]),
      .main_i      (main_dly[c*OUT_W +: OUT_W]),
      .chk_i       (chk_out_i[c*OUT_W +: OUT_W]),
      .react_cfg_i (react_cfg),
      .fault_o     (fault_o[c]),
      .react_o     (ch_react),
      .first_diff_o(first_diff_o[c*OUT_W +: OUT_W])
    );

    assign react_o[c*2 +: 2] = ch_react;
  end
endmodule

// File: rtl/lockstep_cmp_chk.sv
module lockstep_cmp_chk #(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned OUT_W  = 8,
  parameter int unsigned NUM_CH = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic [NUM_CH-1:0]       clr_i,
  input logic [IN_W-1:0]         main_in_i,
  input logic [IN_W-1:0]         chk_in_o,
  input logic [NUM_CH*OUT_W-1:0] main_dly,
  input logic [NUM_CH*OUT_W-1:0] chk_out_i,
  input logic                    cmp_vld,
  input logic [NUM_CH-1:0]       fault_o,
  input logic [NUM_CH*2-1:0]     react_o,
  input logic [NUM_CH*OUT_W-1:0] first_diff_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 1'b1;
  end

  // R1
  in_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (chk_in_o == $past(main_in_i, 2)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R3
    fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_o[c] && !clr_i[c]) |=> fault_o[c]);

    // R4
    det_over_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_vld && (main_dly[c*OUT_W +: OUT_W] != chk_out_i[c*OUT_W +: OUT_W])) |=> fault_o[c]);

    // R5
    no_fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !fault_o[c]) |=> !fault_o[c]);

    // R6
    warm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fault_o[c]) |-> ($past(en_i) && $past(en_i, 2) && $past(en_i, 3)));

    // R7
    cap_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o[c] |-> (first_diff_o[c*OUT_W +: OUT_W] != '0));

    // R7
    cap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_o[c] && !clr_i[c]) |=> $stable(first_diff_o[c*OUT_W +: OUT_W]));

    // R8
    react_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fault_o[c] |-> (react_o[c*2 +: 2] == 2'd0));
  end
endmodule

bind lockstep_cmp lockstep_cmp_chk #(
  .IN_W  (IN_W),
  .OUT_W (OUT_W),
  .NUM_CH(NUM_CH)
) u_lockstep_cmp_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .clr_i       (clr_i),
  .main_in_i   (main_in_i),
  .chk_in_o    (chk_in_o),
  .main_dly    (main_dly),
  .chk_out_i   (chk_out_i),
  .cmp_vld     (cmp_vld),
  .fault_o     (fault_o),
  .react_o     (react_o),
  .first_diff_o(first_diff_o)
);

// File: tb/lockstep_cmp_bench.sv
module lockstep_cmp_bench;
  localparam int unsigned CLK_P = 10;
  localparam int unsigned IW    = 16;
  localparam int unsigned OW    = 8;
  localparam int unsigned NC    = 2;
  localparam int unsigned BW    = NC * OW;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          en_i;
  logic [1:0]    react_cfg_i;
  logic [NC-1:0] clr_i;
  logic [IW-1:0] main_in_i;
  logic [IW-1:0] chk_in_o;
  logic [BW-1:0] main_out_i;
  logic [BW-1:0] chk_out_i;
  logic [NC-1:0] fault_o;
  logic [NC*2-1:0] react_o;
  logic [BW-1:0] first_diff_o;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic [IW-1:0] e_ci1, e_ci2;
  logic [BW-1:0] h1, h2;
  logic [1:0]    ev;
  logic [NC-1:0] e_fault;
  logic [BW-1:0] e_cap;
  logic [NC*2-1:0] e_react;

  always #(CLK_P/2) clk = ~clk;

  lockstep_cmp #(.IN_W(IW), .OUT_W(OW), .NUM_CH(NC)) u_lockstep_cmp (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .react_cfg_i (react_cfg_i),
    .clr_i       (clr_i),
    .main_in_i   (main_in_i),
    .chk_in_o    (chk_in_o),
    .main_out_i  (main_out_i),
    .chk_out_i   (chk_out_i),
    .fault_o     (fault_o),
    .react_o     (react_o),
    .first_diff_o(first_diff_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] pick_inj();
    int r;
    r = int'($urandom % 100);
    if (r < 3)      return OW'(1) << ($urandom % OW);
    else if (r < 6) return (OW'(1) << ($urandom % OW)) | (OW'(1) << ($urandom % OW)) | OW'(8'h81);
    else            return '0;
  endfunction

  // one cycle: drive at negedge, predict, check at next negedge
  task automatic step(input logic en, input logic [NC-1:0] clr, input logic [1:0] rc,
                      input logic [BW-1:0] inj);
    logic [IW-1:0] mi;
    logic [BW-1:0] mo;
    logic          vld;
    logic          det;
    mi = IW'($urandom);
    mo = BW'($urandom);
    en_i        = en;
    clr_i       = clr;
    react_cfg_i = rc;
    main_in_i   = mi;
    main_out_i  = mo;
    chk_out_i   = h2 ^ inj;
    vld = en && ev[0] && ev[1];
    for (int c = 0; c < NC; c++) begin
      det = vld && (inj[c*OW +: OW] != '0);
      if (det && !e_fault[c]) begin
        e_cap[c*OW +: OW] = inj[c*OW +: OW];
        e_react[c*2 +: 2] = rc;
      end else if (clr[c] && !det) begin
        e_cap[c*OW +: OW] = '0;
        e_react[c*2 +: 2] = 2'd0;
      end
      e_fault[c] = det | (e_fault[c] & ~clr[c]);
    end
    ev    = {ev[0], en};
    e_ci2 = e_ci1;
    e_ci1 = mi;
    h2    = h1;
    h1    = mo;
    @(posedge clk);
    @(negedge clk);
    check("R1 chk_in", 64'(chk_in_o), 64'(e_ci2));
    for (int c = 0; c < NC; c++) begin
      check("R2 R3 R4 R5 R6 R9 fault", 64'(fault_o[c]), 64'(e_fault[c]));
      check("R7 first_diff", 64'(first_diff_o[c*OW +: OW]), 64'(e_cap[c*OW +: OW]));
      check("R8 react", 64'(react_o[c*2 +: 2]), 64'(e_react[c*2 +: 2]));
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [BW-1:0] inj;
    void'($urandom(32'h1a2b3c4d));
    rst_ni = 1'b0; en_i = 1'b0; clr_i = '0; react_cfg_i = '0;
    main_in_i = '0; main_out_i = '0; chk_out_i = '0;
    e_ci1 = '0; e_ci2 = '0; h1 = '0; h2 = '0; ev = '0;
    e_fault = '0; e_cap = '0; e_react = '0;
    repeat (3) @(negedge clk);
    // reset state (R3 R7 R8)
    check("R3 reset fault", 64'(fault_o), 64'(0));
    check("R7 reset capture", 64'(first_diff_o), 64'(0));
    check("R8 reset react", 64'(react_o), 64'(0));
    check("R1 reset chk_in", 64'(chk_in_o), 64'(0));
    rst_ni = 1'b1;

    // R6: injections in the first two enabled cycles are ignored
    step(1'b1, '0, 2'd1, BW'(16'h0001));
    step(1'b1, '0, 2'd1, BW'(16'h0080));
    check("R6 warm-up no fault", 64'(fault_o), 64'(0));
    // R2: first valid compare, single-bit on channel 0
    step(1'b1, '0, 2'd2, BW'(16'h0010));
    check("R2 fault raised", 64'(fault_o[0]), 64'(1));
    check("R9 other channel clean", 64'(fault_o[1]), 64'(0));
    check("R8 react captured", 64'(react_o[1:0]), 64'(2));
    // R7: later multi-bit mismatch keeps first capture
    step(1'b1, '0, 2'd3, BW'(16'h00f0));
    check("R7 capture held", 64'(first_diff_o[7:0]), 64'(8'h10));
    // R4: clear together with mismatch, fault stays
    step(1'b1, 2'b01, 2'd0, BW'(16'h0003));
    check("R4 detect beats clear", 64'(fault_o[0]), 64'(1));
    // R3: plain clear
    step(1'b1, 2'b01, 2'd0, '0);
    check("R3 cleared", 64'(fault_o[0]), 64'(0));
    check("R7 capture cleared", 64'(first_diff_o[7:0]), 64'(0));
    // R5: disabled, mismatches ignored
    for (int i = 0; i < 4; i++) step(1'b0, '0, 2'd1, BW'(16'hff01));
    check("R5 disabled no fault", 64'(fault_o), 64'(0));
    // R6: re-enable warm-up, then channel 1 multi-bit
    step(1'b1, '0, 2'd1, BW'(16'h5500));
    step(1'b1, '0, 2'd1, BW'(16'h5500));
    check("R6 re-enable warm-up", 64'(fault_o), 64'(0));
    step(1'b1, '0, 2'd3, BW'(16'ha500));
    check("R9 channel 1 fault", 64'(fault_o), 64'(2'b10));
    check("R7 channel 1 capture", 64'(first_diff_o[15:8]), 64'(8'ha5));
    // R5: fault holds while disabled
    step(1'b0, '0, 2'd0, '0);
    check("R5 fault held when off", 64'(fault_o[1]), 64'(1));
    step(1'b0, 2'b10, 2'd0, '0);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic          en;
      logic [NC-1:0] clr;
      en = ($urandom % 100) < 92;
      for (int c = 0; c < NC; c++) begin
        clr[c] = ($urandom % 100) < 8;
        inj[c*OW +: OW] = pick_inj();
      end
      step(en, clr, 2'($urandom), inj);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule